// File: doc/BRIEF.md
# Display Identification Block Reader

This block pulls the 128-byte display identification structure out of a sink device over an I2C-over-AUX side channel. If the first block says an extension follows, it also pulls the 128-byte extension that comes after it. It does not drive the wire. Each request goes as a command to a lower channel engine, which returns one reply per command. Each reply carries a status code and, for reads, a 16-byte payload.

The work is split into 16-byte segments. For each segment the reader first sends a one-byte I2C write that carries the segment's offset, with the middle-of-transaction flag held so that the bus stays claimed. It then sends a 16-byte I2C read. When the sink answers a read with a defer, the next attempt repeats only the read.

Failed segments are retried, and a fetch that cannot finish is restarted from offset 0 a bounded number of times. Bytes leave through a plain write port meant to feed a 256-byte result memory. When a fetch ends, the block pulses done together with the byte count, or pulses error.

Top module: `disp_id_fetch`

## Requirements
- R1: Segment n of block b is requested at offset b*128 + n*16. Its 16 payload bytes are written one per cycle to result addresses offset+0 through offset+15, in order.
- R2: The address-select command has cmd_is_read_o=0, cmd_mot_o=1, cmd_len_o=1, cmd_addr_o equal to DEV_ADDR (default 0x50) with every upper bit zero, and cmd_wbyte_o equal to the segment offset. The status of its reply does not change what the reader does next.
- R3: The read command has cmd_is_read_o=1, cmd_mot_o=0 and cmd_len_o=16. Every attempt starts with a one-cycle buf_clr_o pulse, and the attempt's first command follows it in the next cycle.
- R4: Reply codes are 0 = acknowledged, 1 = AUX defer, 2 = I2C defer and 3 = failure. After a defer (1 or 2) the next attempt issues only the read. After a failure (3) the next attempt starts again with the address select.
- R5: A segment gets at most 10 read attempts. When the 10th attempt is not acknowledged, the current fetch is abandoned.
- R6: After block 0 completes, a nonzero byte at result index 126 starts block 1, at offsets 128 through 255. A zero byte there ends the fetch after 128 bytes.
- R7: An abandoned fetch restarts from offset 0 with block 1 disarmed, up to 3 fetches in total.
- R8: After reset, busy_o, done_o, err_o, cmd_valid_o and buf_we_o are 0 and size_o is 0. Success gives a one-cycle done_o with size_o at 128, or at 256 when the extension was read. Three abandoned fetches give a one-cycle err_o with size_o at 0.
- R9: A start_i pulse while busy_o is high has no effect on the fetch in progress.
- R10: While cmd_valid_o is high and cmd_ready_i is low, the command and its fields hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Pulse to begin a fetch when idle |
| busy_o | output | 1 | Fetch in progress |
| done_o | output | 1 | One-cycle pulse on success |
| err_o | output | 1 | One-cycle pulse when all fetches failed |
| size_o | output | 9 | Bytes fetched: 0, 128 or 256 |
| cmd_valid_o | output | 1 | Command offered to the channel engine |
| cmd_ready_i | input | 1 | Channel engine takes the command |
| cmd_is_read_o | output | 1 | 1 for I2C read, 0 for I2C write |
| cmd_mot_o | output | 1 | Middle-of-transaction flag |
| cmd_addr_o | output | 20 | Request address; the device address sits in the low field |
| cmd_len_o | output | 5 | Payload length in bytes |
| cmd_wbyte_o | output | 8 | Write payload byte (segment offset) |
| buf_clr_o | output | 1 | Clear the channel data buffer before an attempt |
| rsp_valid_i | input | 1 | One-cycle reply strobe |
| rsp_code_i | input | 2 | Reply status code |
| rsp_data_i | input | 128 | Read payload, byte k in bits 8k+7:8k |
| buf_we_o | output | 1 | Result memory write enable |
| buf_addr_o | output | 8 | Result memory write address |
| buf_wdata_o | output | 8 | Result memory write data |

## Verification
The bench aims at the retry edges. It fails exactly nine reads of one segment, where a reader that counts one too few would start a second fetch. It fails ten, where a reader that never gives up would keep retrying, and one that gives up wrongly would not start again from offset 0. Defer and failure replies are mixed in a known order, and the select commands are counted. A reader that re-selected after a defer, or skipped the select after a failure, shows a different count. Runs with the extension flag zero and nonzero, a refused select reply and a second start while busy catch three more mistakes: a wrong stop after block 0, a reader that reacts to select status, and one that restarts mid-fetch.

// File: rtl/disp_id_pkg.sv
package disp_id_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_CLR      = 3'd1,
    ST_SEL_REQ  = 3'd2,
    ST_SEL_WAIT = 3'd3,
    ST_RD_REQ   = 3'd4,
    ST_RD_WAIT  = 3'd5,
    ST_COPY     = 3'd6,
    ST_NEXT     = 3'd7
  } fetch_st_e;

  typedef enum logic [1:0] {
    RSP_ACK       = 2'd0,
    RSP_AUX_DEFER = 2'd1,
    RSP_I2C_DEFER = 2'd2,
    RSP_FAIL      = 2'd3
  } rsp_code_e;

  function automatic logic code_is_defer(input logic [1:0] code);
    return (code == RSP_AUX_DEFER) || (code == RSP_I2C_DEFER);
  endfunction

endpackage

// File: rtl/disp_id_tally.sv
module disp_id_tally #(
  parameter int LIMIT = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q <= '0;
    end else if (inc_i) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign last_o = (cnt_q == CW'(LIMIT - 1));

  // R5 / R7: the sequencer never asks to count past its limit
  assert_no_overcount_R5: assert property (@(posedge clk) disable iff (rst)
    inc_i |-> !last_o);

endmodule

// File: rtl/disp_id_seg_copy.sv
module disp_id_seg_copy #(
  parameter int SEG_BYTES = 16,
  parameter int ADDR_W    = 8,
  parameter int EXT_IDX   = 126
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load_i,
  input  logic [ADDR_W-1:0]      base_i,
  input  logic [SEG_BYTES*8-1:0] seg_i,
  input  logic                   flag_clr_i,
  output logic                   active_o,
  output logic                   ext_flag_o,
  output logic                   wr_en_o,
  output logic [ADDR_W-1:0]      wr_addr_o,
  output logic [7:0]             wr_data_o
);
  localparam int IW = $clog2(SEG_BYTES);

  logic [7:0]        data_q [SEG_BYTES];
  logic [IW-1:0]     idx_q;
  logic [ADDR_W-1:0] base_q;
  logic              active_q;
  logic              ext_q;
  logic              wr_en_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [7:0]        wr_data_q;
  logic [ADDR_W-1:0] cur_addr;

  assign cur_addr = base_q + ADDR_W'(idx_q);

  // payload bank: parallel load, no reset needed on data
  always_ff @(posedge clk) begin
    if (load_i) begin
      for (int k = 0; k < SEG_BYTES; k++) begin
        data_q[k] <= seg_i[k*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q  <= 1'b0;
      idx_q     <= '0;
      base_q    <= '0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      wr_en_q <= 1'b0;
      if (load_i) begin
        active_q <= 1'b1;
        idx_q    <= '0;
        base_q   <= base_i;
      end else if (active_q) begin
        wr_en_q   <= 1'b1;
        wr_addr_q <= cur_addr;
        wr_data_q <= data_q[idx_q];
        idx_q     <= idx_q + IW'(1);
        if (idx_q == IW'(SEG_BYTES - 1)) begin
          active_q <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flag_clr_i) begin
      ext_q <= 1'b0;
    end else if (active_q && (cur_addr == ADDR_W'(EXT_IDX))) begin
      ext_q <= (data_q[idx_q] != 8'h00);
    end
  end

  assign active_o   = active_q;
  assign ext_flag_o = ext_q;
  assign wr_en_o    = wr_en_q;
  assign wr_addr_o  = wr_addr_q;
  assign wr_data_o  = wr_data_q;

  // R1: a new segment never lands on top of one still being written out
  assert_no_reload_R1: assert property (@(posedge clk) disable iff (rst)
    load_i |-> !active_q);

  // R1: the write run ends on the last byte of an aligned segment
  assert_run_aligned_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(active_q) |-> (wr_en_q && (wr_addr_q[IW-1:0] == IW'(SEG_BYTES - 1))));

endmodule

// File: rtl/disp_id_seq.sv
module disp_id_seq
  import disp_id_pkg::*;
#(
  parameter int SEG_BYTES   = 16,
  parameter int BLK_BYTES   = 128,
  parameter int SEG_TRIES   = 10,
  parameter int FETCH_TRIES = 3
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                start_i,
  input  logic                                cmd_ready_i,
  input  logic                                rsp_valid_i,
  input  logic [1:0]                          rsp_code_i,
  input  logic                                copy_active_i,
  input  logic                                ext_flag_i,
  output logic                                busy_o,
  output logic                                done_o,
  output logic                                err_o,
  output logic [$clog2(2*BLK_BYTES+1)-1:0]    size_o,
  output logic                                cmd_valid_o,
  output logic                                cmd_is_read_o,
  output logic [$clog2(2*BLK_BYTES)-1:0]      offset_o,
  output logic                                buf_clr_o,
  output logic                                copy_load_o,
  output logic                                flag_clr_o
);
  localparam int SEGS_PER_BLK = BLK_BYTES / SEG_BYTES;
  localparam int SEG_IW       = $clog2(SEGS_PER_BLK);
  localparam int SEG_SH       = $clog2(SEG_BYTES);
  localparam int BLK_SH       = $clog2(BLK_BYTES);
  localparam int ADDR_W       = $clog2(2*BLK_BYTES);
  localparam int SIZE_W       = $clog2(2*BLK_BYTES+1);

  fetch_st_e         state_q;
  logic              blk_q;
  logic [SEG_IW-1:0] seg_q;
  logic              defer_q;
  logic              done_q;
  logic              err_q;
  logic [SIZE_W-1:0] size_q;

  logic go, rd_reply, rd_ok, rd_bad, try_last, out_last;
  logic seg_fail, try_inc, try_clr, out_inc, out_clr, seg_end;

  always_comb begin
    go       = (state_q == ST_IDLE) && start_i;
    rd_reply = (state_q == ST_RD_WAIT) && rsp_valid_i;
    rd_ok    = rd_reply && (rsp_code_i == RSP_ACK);
    rd_bad   = rd_reply && (rsp_code_i != RSP_ACK);
    seg_fail = rd_bad && try_last;
    try_inc  = rd_bad && !try_last;
    try_clr  = go || seg_fail || (state_q == ST_NEXT);
    out_inc  = seg_fail && !out_last;
    out_clr  = go;
    seg_end  = (seg_q == SEG_IW'(SEGS_PER_BLK - 1));
  end

  disp_id_tally #(.LIMIT(SEG_TRIES)) u_try_cnt (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (try_clr),
    .inc_i  (try_inc),
    .last_o (try_last)
  );

  disp_id_tally #(.LIMIT(FETCH_TRIES)) u_fetch_cnt (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (out_clr),
    .inc_i  (out_inc),
    .last_o (out_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      blk_q   <= 1'b0;
      seg_q   <= '0;
      defer_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      size_q  <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            blk_q   <= 1'b0;
            seg_q   <= '0;
            defer_q <= 1'b0;
            size_q  <= '0;
            state_q <= ST_CLR;
          end
        end
        ST_CLR: begin
          state_q <= defer_q ? ST_RD_REQ : ST_SEL_REQ;
        end
        ST_SEL_REQ: begin
          if (cmd_ready_i) state_q <= ST_SEL_WAIT;
        end
        ST_SEL_WAIT: begin
          if (rsp_valid_i) state_q <= ST_RD_REQ;
        end
        ST_RD_REQ: begin
          if (cmd_ready_i) state_q <= ST_RD_WAIT;
        end
        ST_RD_WAIT: begin
          if (rsp_valid_i) begin
            if (rsp_code_i == RSP_ACK) begin
              defer_q <= 1'b0;
              state_q <= ST_COPY;
            end else if (try_last) begin
              defer_q <= 1'b0;
              if (out_last) begin
                err_q   <= 1'b1;
                size_q  <= '0;
                state_q <= ST_IDLE;
              end else begin
                blk_q   <= 1'b0;
                seg_q   <= '0;
                state_q <= ST_CLR;
              end
            end else begin
              defer_q <= code_is_defer(rsp_code_i);
              state_q <= ST_CLR;
            end
          end
        end
        ST_COPY: begin
          if (!copy_active_i) state_q <= ST_NEXT;
        end
        ST_NEXT: begin
          if (!seg_end) begin
            seg_q   <= seg_q + SEG_IW'(1);
            state_q <= ST_CLR;
          end else if (!blk_q && ext_flag_i) begin
            blk_q   <= 1'b1;
            seg_q   <= '0;
            state_q <= ST_CLR;
          end else begin
            done_q  <= 1'b1;
            size_q  <= blk_q ? SIZE_W'(2*BLK_BYTES) : SIZE_W'(BLK_BYTES);
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = done_q;
  assign err_o         = err_q;
  assign size_o        = size_q;
  assign cmd_valid_o   = (state_q == ST_SEL_REQ) || (state_q == ST_RD_REQ);
  assign cmd_is_read_o = (state_q == ST_RD_REQ);
  assign offset_o      = (ADDR_W'(blk_q) << BLK_SH) | (ADDR_W'(seg_q) << SEG_SH);
  assign buf_clr_o     = (state_q == ST_CLR);
  assign copy_load_o   = rd_ok;
  assign flag_clr_o    = go || seg_fail;

  // R10: an offered command stays put until the engine takes it
  assert_cmd_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_o && !cmd_ready_i) |=>
      (cmd_valid_o && $stable(cmd_is_read_o) && $stable(offset_o)));

  // R3: a buffer clear is followed at once by a command
  assert_clear_then_cmd_R3: assert property (@(posedge clk) disable iff (rst)
    buf_clr_o |=> cmd_valid_o);

  // R4: a deferred read is retried without the address select
  assert_defer_skips_select_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_bad && code_is_defer(rsp_code_i) && !try_last) |=>
      buf_clr_o ##1 (cmd_valid_o && cmd_is_read_o));

  // R4: a failed read is retried starting with the address select
  assert_fail_reselects_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_bad && (rsp_code_i == RSP_FAIL) && !try_last) |=>
      buf_clr_o ##1 (cmd_valid_o && !cmd_is_read_o));

  // R8: size is reported consistently with the outcome
  assert_done_size_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ((size_o == SIZE_W'(BLK_BYTES)) || (size_o == SIZE_W'(2*BLK_BYTES))));
  assert_err_size_R8: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (size_o == '0) && !done_o);

endmodule

// File: rtl/disp_id_fetch.sv
module disp_id_fetch
  import disp_id_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         SEG_BYTES   = 16,
  parameter int         BLK_BYTES   = 128,
  parameter int         SEG_TRIES   = 10,
  parameter int         FETCH_TRIES = 3,
  parameter int         EXT_IDX     = 126
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              start_i,
  output logic                              busy_o,
  output logic                              done_o,
  output logic                              err_o,
  output logic [$clog2(2*BLK_BYTES+1)-1:0]  size_o,
  output logic                              cmd_valid_o,
  input  logic                              cmd_ready_i,
  output logic                              cmd_is_read_o,
  output logic                              cmd_mot_o,
  output logic [19:0]                       cmd_addr_o,
  output logic [$clog2(SEG_BYTES+1)-1:0]    cmd_len_o,
  output logic [7:0]                        cmd_wbyte_o,
  output logic                              buf_clr_o,
  input  logic                              rsp_valid_i,
  input  logic [1:0]                        rsp_code_i,
  input  logic [SEG_BYTES*8-1:0]            rsp_data_i,
  output logic                              buf_we_o,
  output logic [$clog2(2*BLK_BYTES)-1:0]    buf_addr_o,
  output logic [7:0]                        buf_wdata_o
);
  localparam int ADDR_W = $clog2(2*BLK_BYTES);
  localparam int LEN_W  = $clog2(SEG_BYTES+1);

  logic              copy_active, ext_flag, copy_load, flag_clr;
  logic [ADDR_W-1:0] offset;

  disp_id_seq #(
    .SEG_BYTES   (SEG_BYTES),
    .BLK_BYTES   (BLK_BYTES),
    .SEG_TRIES   (SEG_TRIES),
    .FETCH_TRIES (FETCH_TRIES)
  ) u_seq (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .cmd_ready_i   (cmd_ready_i),
    .rsp_valid_i   (rsp_valid_i),
    .rsp_code_i    (rsp_code_i),
    .copy_active_i (copy_active),
    .ext_flag_i    (ext_flag),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .err_o         (err_o),
    .size_o        (size_o),
    .cmd_valid_o   (cmd_valid_o),
    .cmd_is_read_o (cmd_is_read_o),
    .offset_o      (offset),
    .buf_clr_o     (buf_clr_o),
    .copy_load_o   (copy_load),
    .flag_clr_o    (flag_clr)
  );

  disp_id_seg_copy #(
    .SEG_BYTES (SEG_BYTES),
    .ADDR_W    (ADDR_W),
    .EXT_IDX   (EXT_IDX)
  ) u_copy (
    .clk        (clk),
    .rst        (rst),
    .load_i     (copy_load),
    .base_i     (offset),
    .seg_i      (rsp_data_i),
    .flag_clr_i (flag_clr),
    .active_o   (copy_active),
    .ext_flag_o (ext_flag),
    .wr_en_o    (buf_we_o),
    .wr_addr_o  (buf_addr_o),
    .wr_data_o  (buf_wdata_o)
  );

  // command field formatting: select = 1-byte write with MOT, read = full segment
  assign cmd_mot_o   = cmd_valid_o && !cmd_is_read_o;
  assign cmd_len_o   = cmd_is_read_o ? LEN_W'(SEG_BYTES) : LEN_W'(1);
  assign cmd_addr_o  = {13'd0, DEV_ADDR};
  assign cmd_wbyte_o = 8'(offset);

  // R2: a select command is always preceded by a buffer clear or a reply
  assert_select_after_clear_R2: assert property (@(posedge clk) disable iff (rst)
    ($rose(cmd_valid_o) && !cmd_is_read_o) |-> $past(buf_clr_o));

  // R1: result writes only happen while a fetch is running
  assert_write_in_fetch_R1: assert property (@(posedge clk) disable iff (rst)
    buf_we_o |-> busy_o);

endmodule

// File: tb/disp_id_fetch_tb.sv
module disp_id_fetch_tb;
  localparam int CLK_NS = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic         busy_o, done_o, err_o;
  logic [8:0]   size_o;
  logic         cmd_valid_o, cmd_is_read_o, cmd_mot_o, buf_clr_o;
  logic         cmd_ready_i = 1'b0;
  logic [19:0]  cmd_addr_o;
  logic [4:0]   cmd_len_o;
  logic [7:0]   cmd_wbyte_o;
  logic         rsp_valid_i = 1'b0;
  logic [1:0]   rsp_code_i = 2'd0;
  logic [127:0] rsp_data_i = '0;
  logic         buf_we_o;
  logic [7:0]   buf_addr_o, buf_wdata_o;

  always #(CLK_NS/2) clk = ~clk;

  disp_id_fetch u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
    .err_o(err_o), .size_o(size_o), .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i),
    .cmd_is_read_o(cmd_is_read_o), .cmd_mot_o(cmd_mot_o), .cmd_addr_o(cmd_addr_o),
    .cmd_len_o(cmd_len_o), .cmd_wbyte_o(cmd_wbyte_o), .buf_clr_o(buf_clr_o),
    .rsp_valid_i(rsp_valid_i), .rsp_code_i(rsp_code_i), .rsp_data_i(rsp_data_i),
    .buf_we_o(buf_we_o), .buf_addr_o(buf_addr_o), .buf_wdata_o(buf_wdata_o)
  );

  int n_tests = 0, n_fail = 0;
  logic [7:0] img [256];
  logic [7:0] res [256];
  int sel_cnt, rd_cnt, clr_cnt, wr_cnt, proto_bad, off_bad;
  int scr_err, scr_def;
  bit fail_all, sel_nack;
  int dev_ptr = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // channel engine model
  initial begin
    forever begin
      @(negedge clk);
      rsp_valid_i = 1'b0;
      cmd_ready_i = 1'b0;
      if (!rst && cmd_valid_o && ($urandom_range(0, 2) != 0)) begin
        bit is_rd;
        is_rd = cmd_is_read_o;
        cmd_ready_i = 1'b1;
        if (!is_rd) begin
          sel_cnt++;
          if (!cmd_mot_o || cmd_len_o != 5'd1 || cmd_addr_o != 20'h00050) proto_bad++;
          if (cmd_wbyte_o[3:0] != 4'd0) off_bad++;
          dev_ptr = cmd_wbyte_o;
        end else begin
          rd_cnt++;
          if (cmd_mot_o || cmd_len_o != 5'd16) proto_bad++;
        end
        @(negedge clk);
        cmd_ready_i = 1'b0;
        repeat ($urandom_range(0, 3)) @(negedge clk);
        rsp_data_i = '0;
        if (!is_rd) begin
          rsp_code_i = (sel_nack && $urandom_range(0, 1) == 1) ? 2'd3 : 2'd0;
        end else if (fail_all || scr_err > 0) begin
          if (!fail_all) scr_err--;
          rsp_code_i = 2'd3;
        end else if (scr_def > 0) begin
          scr_def--;
          rsp_code_i = ($urandom_range(0, 1) == 1) ? 2'd1 : 2'd2;
        end else begin
          rsp_code_i = 2'd0;
          for (int k = 0; k < 16; k++) rsp_data_i[k*8 +: 8] = img[(dev_ptr + k) % 256];
          dev_ptr = (dev_ptr + 16) % 256;
        end
        rsp_valid_i = 1'b1;
      end
    end
  end

  // output monitor
  initial begin
    forever begin
      @(negedge clk);
      if (buf_we_o) begin
        res[buf_addr_o] = buf_wdata_o;
        wr_cnt++;
      end
      if (buf_clr_o) clr_cnt++;
    end
  end

  // expected outcome from the requirements: failures first, then defers
  task automatic model(input int e, input int d, input bit all_f, input bit ext,
                       output int x_sel, output int x_rd, output int x_wr,
                       output int x_size, output bit x_err);
    int ee, dd, segs;
    bit fetched, ok, last_def, seg_ok;
    ee = e; dd = d; fetched = 0;
    x_sel = 0; x_rd = 0; x_wr = 0; x_size = 0;
    for (int o = 0; o < 3 && !fetched; o++) begin
      ok = 1; segs = 8;
      for (int s = 0; s < segs && ok; s++) begin
        last_def = 0; seg_ok = 0;
        for (int t = 0; t < 10 && !seg_ok; t++) begin
          if (!last_def) x_sel++;
          x_rd++;
          if (all_f || ee > 0) begin
            if (!all_f) ee--;
            last_def = 0;
          end else if (dd > 0) begin
            dd--;
            last_def = 1;
          end else begin
            seg_ok = 1;
          end
        end
        if (!seg_ok) ok = 0;
        else x_wr += 16;
        if (ok && s == 7 && ext) segs = 16;
      end
      if (ok) begin
        fetched = 1;
        x_size = ext ? 256 : 128;
      end
    end
    x_err = !fetched;
  endtask

  task automatic run_case(input string name, input int e, input int d, input logic [7:0] ext_b,
                          input bit all_f, input bit nack, input bit mid_start);
    int x_sel, x_rd, x_wr, x_size, cyc, bad, rd_end;
    bit x_err, got_done, got_err;
    int got_size;
    for (int k = 0; k < 256; k++) begin
      img[k] = 8'($urandom);
      res[k] = 8'hA5;
    end
    img[126] = ext_b;
    model(e, d, all_f, ext_b != 8'h00, x_sel, x_rd, x_wr, x_size, x_err);
    sel_cnt = 0; rd_cnt = 0; clr_cnt = 0; wr_cnt = 0; proto_bad = 0; off_bad = 0;
    scr_err = e; scr_def = d; fail_all = all_f; sel_nack = nack;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    cyc = 0; got_done = 0; got_err = 0; got_size = 0;
    while (!got_done && !got_err && cyc < 20000) begin
      if (mid_start && cyc == 40) start_i = 1'b1;
      if (mid_start && cyc == 41) start_i = 1'b0;
      @(negedge clk);
      cyc++;
      got_done = done_o;
      got_err = err_o;
      got_size = size_o;
    end
    $display("[TB] case %s", name);
    chk(cyc < 20000, "R8", {name, " finished"}, cyc, 20000);
    chk(got_err == x_err && got_done == !x_err, "R8", {name, " outcome err"}, got_err, x_err);
    chk(got_size == x_size, "R8", {name, " size"}, got_size, x_size);
    @(negedge clk);
    chk(!done_o && !err_o, "R8", {name, " one-cycle pulse"}, done_o | err_o, 0);
    chk(sel_cnt == x_sel, "R4", {name, " select count"}, sel_cnt, x_sel);
    chk(rd_cnt == x_rd, "R5", {name, " read count"}, rd_cnt, x_rd);
    chk(clr_cnt == rd_cnt, "R3", {name, " clears per attempt"}, clr_cnt, rd_cnt);
    chk(proto_bad == 0, "R2", {name, " command fields"}, proto_bad, 0);
    chk(off_bad == 0, "R1", {name, " offset alignment"}, off_bad, 0);
    chk(wr_cnt == x_wr, "R6", {name, " bytes written"}, wr_cnt, x_wr);
    bad = 0;
    for (int k = 0; k < x_size; k++) if (res[k] !== img[k]) bad++;
    chk(bad == 0, "R1", {name, " result bytes"}, bad, 0);
    rd_end = rd_cnt;
    repeat (50) @(negedge clk);
    chk(rd_cnt == rd_end && !busy_o, "R9", {name, " idle after end"}, rd_cnt, rd_end);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (5) @(negedge clk);
    chk(!busy_o && !done_o && !err_o && size_o == 0, "R8", "reset status", size_o, 0);
    chk(!cmd_valid_o && !buf_we_o && !buf_clr_o, "R8", "reset idle outputs", cmd_valid_o, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !cmd_valid_o, "R8", "idle after reset", busy_o, 0);

    run_case("R6 base only", 0, 0, 8'h00, 0, 0, 0);
    run_case("R6 with extension", 0, 0, 8'h01, 0, 0, 0);
    run_case("R4 defers", 0, 5, 8'h00, 0, 0, 0);
    run_case("R4 failures then defers", 3, 4, 8'h80, 0, 0, 0);
    run_case("R5 nine misses", 2, 7, 8'h00, 0, 0, 0);
    run_case("R7 ten misses restart", 4, 6, 8'h02, 0, 0, 0);
    run_case("R7 twelve failures", 12, 0, 8'h00, 0, 0, 0);
    run_case("R8 all fail", 0, 0, 8'h00, 1, 0, 0);
    run_case("R2 select refused", 1, 2, 8'hFF, 0, 1, 0);
    run_case("R9 start while busy", 0, 2, 8'h00, 0, 0, 1);
    for (int i = 0; i < 10; i++) begin
      run_case("random", $urandom_range(0, 6), $urandom_range(0, 6),
               ($urandom_range(0, 1) == 1) ? 8'($urandom_range(1, 255)) : 8'h00,
               0, $urandom_range(0, 1) == 1, 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R8 watchdog expired: got 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule